// File: doc/BRIEF.md
# Synchronized Multi-Channel Timer Bank

This block holds six 16-bit up-counters behind a small word-wide register port. Each channel has a counter, a compare value and a 2-bit clear-source select. All counters advance together on every clock in which the shared `cnt_en` input is high. A 6-bit group mask links any subset of the channels. Once two or more channels are linked, a counter write to any member presets every member in the same cycle. A compare-match clear on one member can also reset the members that are set to follow their peers.

Software programs the group mask, the compare values and the clear selects. It then reads counters back through the same port. A bus write always wins over counting and clearing in the cycle it lands. The block has no state machine. The only sequential elements are the mask register and the per-channel registers, each with an active-low asynchronous reset.

Top module: `sync_timer_bank`

## Requirements
- R1: After reset the group mask, every counter and every clear select read 0, and every compare register reads 0xFFFF.
- R2: The group mask lives at address 0x00. Bits 5..0 are the per-channel link bits, written from `bus_wdata[5:0]`. All other bits read as 0, and writing 1 to them has no effect.
- R3: A counter that is not written or cleared in a cycle adds 1 when `cnt_en` is high and holds when it is low. It wraps from 0xFFFF to 0x0000.
- R4: Clear-select code 01 (own match) makes the counter read 0 on the clock after it equals its compare value. This clear has priority over counting.
- R5: With fewer than two link bits set, a counter write loads only the addressed counter, even if that channel's link bit is 1.
- R6: With two or more link bits set, a counter write to a linked channel loads the written value into every linked counter on the same edge. Unlinked counters are unaffected.
- R7: A linked channel with clear-select code 10 (peer) reads 0 on the same edge on which any linked channel is cleared by its own compare match.
- R8: Peer clearing needs both the link bit and code 10. An unlinked channel with code 10 keeps counting. Codes 00 and 11 never clear.
- R9: A counter write in a cycle takes priority over that counter's own-match clear, peer clear and count.
- R10: The register map is as follows: mask at 0x00; counter n at 0x02+2n; compare n at 0x12+2n; clear select n at 0x22+2n, reading back in bits 1..0. Every other address reads 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Shared count enable for all channels |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |

## Verification
The bench builds the block with its default values: six channels and 16-bit counters. This exercises every possible link pattern, including the single-bit case that must stay independent. It also covers both edges of the full word range. During random traffic, compare and counter writes are narrowed to small values. This makes own-match and peer clears happen often, and lets them collide with group presets and counting. Directed cases preload 0xFFFE to reach the wrap point, and use a compare value of 0 to set a write against a pending clear.

// File: rtl/stb_pkg.sv
package stb_pkg;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_OWN  = 2'b01,
        CLR_PEER = 2'b10,
        CLR_RSVD = 2'b11
    } clr_src_e;

    localparam int SYNC_ADDR = 'h00;
    localparam int CNT_BASE  = 'h02;
    localparam int CMP_BASE  = 'h12;
    localparam int CSEL_BASE = 'h22;
    localparam int ADDR_STEP = 2;

endpackage

// File: rtl/stb_sync_ctrl.sv
module stb_sync_ctrl #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] sync_q,
    output logic [NUM_CH-1:0] member
);
    localparam int MIN_GROUP = 2;

    logic group_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else if (we) begin
            sync_q <= wbits;
        end
    end

    always_comb begin
        group_active = ($countones(sync_q) >= MIN_GROUP);
        member       = group_active ? sync_q : '0;
    end

endmodule

// File: rtl/stb_channel.sv
module stb_channel
    import stb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cmp_we,
    input  logic             csel_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             peer_clr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp,
    output logic [1:0]       csel,
    output logic             own_match
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cmp_q;
    clr_src_e         csel_q;

    always_comb begin
        own_match = (csel_q == CLR_OWN) && (cnt_q == cmp_q);
    end

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (own_match) begin
            cnt_d = '0;
        end else if (peer_clr && (csel_q == CLR_PEER)) begin
            cnt_d = '0;
        end else if (cnt_en) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cmp_q  <= '1;
            csel_q <= CLR_NONE;
        end else begin
            cnt_q <= cnt_d;
            if (cmp_we) begin
                cmp_q <= wdata;
            end
            if (csel_we) begin
                csel_q <= clr_src_e'(wdata[1:0]);
            end
        end
    end

    always_comb begin
        cnt  = cnt_q;
        cmp  = cmp_q;
        csel = csel_q;
    end

endmodule

// File: rtl/stb_bus_map.sv
module stb_bus_map
    import stb_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [NUM_CH-1:0]              sync_q,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  cnt_all,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  cmp_all,
    input  logic [NUM_CH-1:0][1:0]         csel_all,
    output logic                           sync_we,
    output logic [NUM_CH-1:0]              cnt_wr,
    output logic [NUM_CH-1:0]              cmp_wr,
    output logic [NUM_CH-1:0]              csel_wr,
    output logic [DATA_W-1:0]              rdata
);
    logic              sync_hit;
    logic [NUM_CH-1:0] cnt_hit;
    logic [NUM_CH-1:0] cmp_hit;
    logic [NUM_CH-1:0] csel_hit;

    assign sync_hit = (bus_addr == ADDR_W'(SYNC_ADDR));
    assign sync_we  = bus_we && sync_hit;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
        assign cnt_hit[n]  = (bus_addr == ADDR_W'(CNT_BASE  + ADDR_STEP * n));
        assign cmp_hit[n]  = (bus_addr == ADDR_W'(CMP_BASE  + ADDR_STEP * n));
        assign csel_hit[n] = (bus_addr == ADDR_W'(CSEL_BASE + ADDR_STEP * n));
        assign cnt_wr[n]   = bus_we && cnt_hit[n];
        assign cmp_wr[n]   = bus_we && cmp_hit[n];
        assign csel_wr[n]  = bus_we && csel_hit[n];
    end

    always_comb begin
        rdata = '0;
        if (sync_hit) begin
            rdata = DATA_W'(sync_q);
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (cnt_hit[n]) begin
                rdata = cnt_all[n];
            end
            if (cmp_hit[n]) begin
                rdata = cmp_all[n];
            end
            if (csel_hit[n]) begin
                rdata = DATA_W'(csel_all[n]);
            end
        end
    end

endmodule

// File: rtl/sync_timer_bank.sv
module sync_timer_bank #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata
);
    logic [NUM_CH-1:0]             sync_q;
    logic [NUM_CH-1:0]             member;
    logic                          sync_we;
    logic [NUM_CH-1:0]             cnt_wr;
    logic [NUM_CH-1:0]             cmp_wr;
    logic [NUM_CH-1:0]             csel_wr;
    logic [NUM_CH-1:0]             own_match;
    logic [NUM_CH-1:0]             load;
    logic [NUM_CH-1:0]             peer_clr;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all;
    logic [NUM_CH-1:0][CNT_W-1:0]  cmp_all;
    logic [NUM_CH-1:0][1:0]        csel_all;
    logic                          group_write;
    logic                          group_clear;

    stb_bus_map #(
        .NUM_CH (NUM_CH),
        .DATA_W (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_map (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .sync_q   (sync_q),
        .cnt_all  (cnt_all),
        .cmp_all  (cmp_all),
        .csel_all (csel_all),
        .sync_we  (sync_we),
        .cnt_wr   (cnt_wr),
        .cmp_wr   (cmp_wr),
        .csel_wr  (csel_wr),
        .rdata    (bus_rdata)
    );

    stb_sync_ctrl #(
        .NUM_CH (NUM_CH)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sync_we),
        .wbits  (bus_wdata[NUM_CH-1:0]),
        .sync_q (sync_q),
        .member (member)
    );

    assign group_write = |(cnt_wr & member);
    assign group_clear = |(own_match & member);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign load[n]     = cnt_wr[n] | (member[n] & group_write);
        assign peer_clr[n] = member[n] & group_clear;

        stb_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_en    (cnt_en),
            .load      (load[n]),
            .load_val  (bus_wdata),
            .cmp_we    (cmp_wr[n]),
            .csel_we   (csel_wr[n]),
            .wdata     (bus_wdata),
            .peer_clr  (peer_clr[n]),
            .cnt       (cnt_all[n]),
            .cmp       (cmp_all[n]),
            .csel      (csel_all[n]),
            .own_match (own_match[n])
        );
    end

endmodule

// File: rtl/stb_checker.sv
module stb_checker
    import stb_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cnt_en,
    input logic                          bus_we,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [CNT_W-1:0]              bus_wdata,
    input logic [CNT_W-1:0]              bus_rdata,
    input logic [NUM_CH-1:0]             sync_q,
    input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all,
    input logic [NUM_CH-1:0][CNT_W-1:0]  cmp_all,
    input logic [NUM_CH-1:0][1:0]        csel_all
);
    logic              grp;
    logic [NUM_CH-1:0] linked;
    logic [NUM_CH-1:0] wr_ch;
    logic [NUM_CH-1:0] match_ch;

    always_comb begin
        grp    = ($countones(sync_q) > 1);
        linked = grp ? sync_q : '0;
        for (int k = 0; k < NUM_CH; k++) begin
            wr_ch[k]    = bus_we && (bus_addr == ADDR_W'(CNT_BASE + ADDR_STEP * k));
            match_ch[k] = (csel_all[k] == 2'b01) && (cnt_all[k] == cmp_all[k]);
        end
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(SYNC_ADDR)) |-> (bus_rdata[CNT_W-1:NUM_CH] == '0));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        logic hit;
        logic peer;
        assign hit  = wr_ch[n] || (linked[n] && |(wr_ch & linked));
        assign peer = linked[n] && (csel_all[n] == 2'b10) && |(match_ch & linked);

        // R9
        write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_ch[n] |=> (cnt_all[n] == $past(bus_wdata)));

        // R6
        group_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !wr_ch[n]) |=> (cnt_all[n] == $past(bus_wdata)));

        // R4
        own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit && match_ch[n]) |=> (cnt_all[n] == '0));

        // R7
        peer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit && peer) |=> (cnt_all[n] == '0));

        // R3
        count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit && !match_ch[n] && !peer && cnt_en)
            |=> (cnt_all[n] == CNT_W'($past(cnt_all[n]) + 1'b1)));

        // R3
        count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit && !match_ch[n] && !peer && !cnt_en) |=> $stable(cnt_all[n]));
    end

endmodule

bind sync_timer_bank stb_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sync_q    (sync_q),
    .cnt_all   (cnt_all),
    .cmp_all   (cmp_all),
    .csel_all  (csel_all)
);

// File: tb/sync_timer_bank_tb.sv
`timescale 1ns/1ps
module sync_timer_bank_tb;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [5:0]  m_sync;
    logic [15:0] m_cnt  [NCH];
    logic [15:0] m_cmp  [NCH];
    logic [1:0]  m_csel [NCH];

    always #2 clk = ~clk;

    sync_timer_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [15:0] model_read(input logic [7:0] a);
        logic [15:0] r = '0;
        if (a == 8'h00) r = {10'b0, m_sync};
        for (int k = 0; k < NCH; k++) begin
            if (a == 8'(8'h02 + 2 * k)) r = m_cnt[k];
            if (a == 8'(8'h12 + 2 * k)) r = m_cmp[k];
            if (a == 8'(8'h22 + 2 * k)) r = {14'b0, m_csel[k]};
        end
        return r;
    endfunction

    task automatic model_reset();
        m_sync = '0;
        for (int k = 0; k < NCH; k++) begin
            m_cnt[k] = '0; m_cmp[k] = 16'hFFFF; m_csel[k] = 2'b00;
        end
    endtask

    task automatic model_tick(input logic we, input logic [7:0] a,
                              input logic [15:0] d, input logic en);
        logic [5:0]  mem, wr, om;
        logic        anyw, anyc;
        logic [15:0] nxt [NCH];
        mem = ($countones(m_sync) >= 2) ? m_sync : 6'b0;
        for (int k = 0; k < NCH; k++) begin
            wr[k] = we && (a == 8'(8'h02 + 2 * k));
            om[k] = (m_csel[k] == 2'b01) && (m_cnt[k] == m_cmp[k]);
        end
        anyw = |(wr & mem);
        anyc = |(om & mem);
        for (int k = 0; k < NCH; k++) begin
            if (wr[k] || (mem[k] && anyw)) nxt[k] = d;
            else if (om[k]) nxt[k] = '0;
            else if (mem[k] && anyc && m_csel[k] == 2'b10) nxt[k] = '0;
            else if (en) nxt[k] = m_cnt[k] + 16'd1;
            else nxt[k] = m_cnt[k];
        end
        for (int k = 0; k < NCH; k++) begin
            m_cnt[k] = nxt[k];
            if (we && a == 8'(8'h12 + 2 * k)) m_cmp[k] = d;
            if (we && a == 8'(8'h22 + 2 * k)) m_csel[k] = d[1:0];
        end
        if (we && a == 8'h00) m_sync = d[5:0];
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // One clock: drive, check the read against the model, clock, update the model.
    task automatic step(input logic we, input logic [7:0] a, input logic [15:0] d,
                        input logic en, input string tag);
        bus_we = we; bus_addr = a; bus_wdata = d; cnt_en = en;
        #1;
        check(tag, bus_rdata, model_read(a));
        @(posedge clk);
        model_tick(we, a, d, en);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        step(1'b1, a, d, 1'b0, "R10");
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
        bus_we = 1'b0; bus_addr = a; cnt_en = 1'b0;
        #1;
        check(tag, bus_rdata, exp);
        @(posedge clk);
        model_tick(1'b0, a, 16'h0, 1'b0);
        @(negedge clk);
    endtask

    task automatic do_reset();
        bus_we = 1'b0; cnt_en = 1'b0; bus_addr = '0; bus_wdata = '0;
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED_1234);
        model_reset();

        // R1 reset values
        do_reset();
        expect_rd(8'h00, 16'h0000, "R1");
        expect_rd(8'h02, 16'h0000, "R1");
        expect_rd(8'h12, 16'hFFFF, "R1");
        expect_rd(8'h22, 16'h0000, "R1");

        // R2 reserved mask bits
        wr(8'h00, 16'hFFFF);
        expect_rd(8'h00, 16'h003F, "R2");

        // R3 wrap and hold
        do_reset();
        wr(8'h02, 16'hFFFE);
        for (int i = 0; i < 3; i++) step(1'b0, 8'h02, 16'h0, 1'b1, "R3");
        expect_rd(8'h02, 16'h0001, "R3");
        expect_rd(8'h02, 16'h0001, "R3");

        // R5 single link bit stays independent
        do_reset();
        wr(8'h00, 16'h0004);
        wr(8'h06, 16'h1111);
        expect_rd(8'h06, 16'h1111, "R5");
        expect_rd(8'h08, 16'h0000, "R5");
        expect_rd(8'h02, 16'h0000, "R5");

        // R6 group preset
        do_reset();
        wr(8'h00, 16'h000D);
        wr(8'h06, 16'h0ABC);
        expect_rd(8'h02, 16'h0ABC, "R6");
        expect_rd(8'h08, 16'h0ABC, "R6");
        expect_rd(8'h04, 16'h0000, "R6");

        // R4 own-match clear, R8 code 00 never clears
        do_reset();
        wr(8'h12, 16'h0003);
        wr(8'h22, 16'h0001);
        wr(8'h14, 16'h0002);
        for (int i = 0; i < 4; i++) step(1'b0, 8'h02, 16'h0, 1'b1, "R4");
        expect_rd(8'h02, 16'h0000, "R4");
        expect_rd(8'h04, 16'h0004, "R8");

        // R7 peer clear, R8 unlinked peer channel keeps counting
        do_reset();
        wr(8'h00, 16'h0003);
        wr(8'h12, 16'h0002);
        wr(8'h22, 16'h0001);
        wr(8'h24, 16'h0002);
        wr(8'h26, 16'h0002);
        for (int i = 0; i < 3; i++) step(1'b0, 8'h04, 16'h0, 1'b1, "R7");
        expect_rd(8'h04, 16'h0000, "R7");
        expect_rd(8'h02, 16'h0000, "R7");
        expect_rd(8'h06, 16'h0003, "R8");

        // R8 reserved code 11 never clears
        do_reset();
        wr(8'h16, 16'h0000);
        wr(8'h26, 16'h0003);
        step(1'b0, 8'h06, 16'h0, 1'b1, "R8");
        step(1'b0, 8'h06, 16'h0, 1'b1, "R8");
        expect_rd(8'h06, 16'h0002, "R8");

        // R9 write beats clear and count
        do_reset();
        wr(8'h12, 16'h0000);
        wr(8'h22, 16'h0001);
        step(1'b1, 8'h02, 16'h0050, 1'b1, "R9");
        step(1'b1, 8'h04, 16'h0007, 1'b1, "R9");
        expect_rd(8'h02, 16'h0051, "R9");
        expect_rd(8'h04, 16'h0007, "R9");

        // R10 unmapped addresses and readback
        expect_rd(8'h0E, 16'h0000, "R10");
        expect_rd(8'h40, 16'h0000, "R10");
        expect_rd(8'h01, 16'h0000, "R10");
        wr(8'h18, 16'hBEEF);
        expect_rd(8'h18, 16'hBEEF, "R10");

        // Random traffic against the model
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a;
            logic [15:0] d;
            logic        we;
            int          kind = $urandom_range(0, 3);
            int          ch = $urandom_range(0, NCH - 1);
            d  = 16'($urandom);
            we = ($urandom_range(0, 3) == 0);
            case (kind)
                0: begin a = 8'h00; end
                1: begin a = 8'(8'h02 + 2 * ch); d = d & 16'h001F; end
                2: begin a = 8'(8'h12 + 2 * ch); d = d & 16'h001F; end
                default: begin a = 8'(8'h22 + 2 * ch); end
            endcase
            if (kind == 1) step(we, a, d, 1'($urandom_range(0, 1)), "R3");
            else if (kind == 0) step(we, a, d, 1'($urandom_range(0, 1)), "R2");
            else step(we, a, d, 1'($urandom_range(0, 1)), "R10");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule